// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a small group of already-synchronized input pins and turns selected activity on them into interrupt status. Each pin is configured on its own for either level sensing or edge sensing. A level-sensed pin reports while it sits at the chosen level. An edge-sensed pin reports a rising edge, a falling edge, or any change. Edge events are captured in a sticky status bit. Software acknowledges that bit by writing a one to it.

Status is gated by a per-pin enable. The gated bits are ORed into one interrupt request line. Software configures and inspects the block over a small byte-wide register port with a write strobe, an index and a combinational read path. The pins are plain level inputs with no handshake. Detection looks at the pin values whatever the pins are otherwise used for, so a pin that the chip drives as an output can still raise interrupts.

Top module: `gpint_unit`

## Requirements
- R1: After reset every configuration register, the enable register and all captured edge bits read 0, and `irq` is low.
- R2: Register index map. 0 is level select (1 = level, 0 = edge), 1 is any-edge, 2 is active-high (1 = high level or rising edge, 0 = low level or falling edge) and 3 is enable; these four read back what was written. 4 is raw status and 5 is gated status, both read-only, and writes to them are ignored. 6 is acknowledge, which is write-only and reads 0. Bit n of every register belongs to pin n.
- R3: In edge mode with any-edge clear, a pin captures a rising edge when active-high is 1 and a falling edge when it is 0. An edge is the pin value differing from its value one clock earlier. The raw bit reads 1 after the clock edge that sees the change.
- R4: When the any-edge bit of an edge-mode pin is 1, both directions of change are captured and the active-high bit is ignored.
- R5: A captured edge bit stays 1 until software writes index 6 with that bit at 1. Bits written as 0 leave their pins unchanged.
- R6: For a level-mode pin, raw status equals (pin == active-high) in the same cycle and drops by itself. Acknowledge writes do not affect it.
- R7: If an acknowledge of a pin and a new qualifying edge on that pin fall in the same clock, the captured bit stays 1.
- R8: Rewriting the level-select, any-edge or active-high settings does not clear an edge bit that is already captured.
- R9: Gated status equals raw status AND enable. `irq` is the OR of the gated bits, so an all-zero enable holds `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | PINS | Synchronized pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | PINS | Write data |
| reg_rdata | output | PINS | Combinational read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that a captured edge bit holds unless it is acknowledged, and that a qualifying edge always sets it, even against a same-cycle acknowledge. They also check that any-edge capture follows every change, that a zero enable keeps `irq` low, and that the acknowledge index reads 0. The bench is needed for what those cycle checks cannot show. It sweeps all five pin modes across all pins with many pin patterns and checks raw status, gated status and `irq` against an arithmetic model. It also covers register readback, acknowledges that leave level status alone, and a captured bit that survives a round trip through level mode.

// File: rtl/gpint_pkg.sv
package gpint_pkg;
  localparam int IDX_W = 3;
  typedef enum logic [IDX_W-1:0] {
    IDX_LVLSEL = 3'd0,
    IDX_ANYEDG = 3'd1,
    IDX_ACTHI  = 3'd2,
    IDX_ENABLE = 3'd3,
    IDX_RAW    = 3'd4,
    IDX_GATED  = 3'd5,
    IDX_ACK    = 3'd6
  } reg_idx_e;
endpackage

// File: rtl/gpint_regs.sv
module gpint_regs #(
  parameter int PINS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [gpint_pkg::IDX_W-1:0] reg_addr,
  input  logic [PINS-1:0]           reg_wdata,
  output logic [PINS-1:0]           lvl_sel,
  output logic [PINS-1:0]           any_edge,
  output logic [PINS-1:0]           act_hi,
  output logic [PINS-1:0]           enable,
  output logic [PINS-1:0]           ack
);
  import gpint_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_sel  <= '0;
      any_edge <= '0;
      act_hi   <= '0;
      enable   <= '0;
    end else if (reg_wr) begin
      case (reg_idx_e'(reg_addr))
        IDX_LVLSEL: lvl_sel  <= reg_wdata;
        IDX_ANYEDG: any_edge <= reg_wdata;
        IDX_ACTHI:  act_hi   <= reg_wdata;
        IDX_ENABLE: enable   <= reg_wdata;
        default: ;
      endcase
    end
  end

  assign ack = (reg_wr && reg_idx_e'(reg_addr) == IDX_ACK) ? reg_wdata : '0;
endmodule

// File: rtl/gpint_pin.sv
module gpint_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic lvl_sel,
  input  logic any_edge,
  input  logic act_hi,
  input  logic ack,
  output logic raw
);
  logic prev;
  logic captured;
  logic hit;

  always_comb begin
    if (any_edge)    hit = pin ^ prev;
    else if (act_hi) hit = pin & ~prev;
    else             hit = ~pin & prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= 1'b0;
      captured <= 1'b0;
    end else begin
      prev <= pin;
      if (!lvl_sel && hit) captured <= 1'b1;
      else if (ack)        captured <= 1'b0;
    end
  end

  assign raw = lvl_sel ? (pin == act_hi) : captured;

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    captured && !ack |=> captured);
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_sel && hit && ack |=> captured);
  a_r4_any_change: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_sel && any_edge && (pin != prev) |=> captured);
  a_r3_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_sel && !any_edge && act_hi && pin && !prev |=> captured);
endmodule

// File: rtl/gpint_unit.sv
module gpint_unit #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_in,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [PINS-1:0] reg_wdata,
  output logic [PINS-1:0] reg_rdata,
  output logic            irq
);
  import gpint_pkg::*;

  logic [PINS-1:0] lvl_sel, any_edge, act_hi, enable, ack;
  logic [PINS-1:0] raw, gated;

  gpint_regs #(.PINS(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .lvl_sel(lvl_sel), .any_edge(any_edge),
    .act_hi(act_hi), .enable(enable), .ack(ack)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    gpint_pin u_pin (
      .clk(clk), .rst_n(rst_n), .pin(pin_in[i]), .lvl_sel(lvl_sel[i]),
      .any_edge(any_edge[i]), .act_hi(act_hi[i]), .ack(ack[i]), .raw(raw[i])
    );
  end

  assign gated = raw & enable;
  assign irq   = |gated;

  always_comb begin
    case (reg_idx_e'(reg_addr))
      IDX_LVLSEL: reg_rdata = lvl_sel;
      IDX_ANYEDG: reg_rdata = any_edge;
      IDX_ACTHI:  reg_rdata = act_hi;
      IDX_ENABLE: reg_rdata = enable;
      IDX_RAW:    reg_rdata = raw;
      IDX_GATED:  reg_rdata = gated;
      default:    reg_rdata = '0;
    endcase
  end

  a_r9_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);
  a_r2_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == IDX_ACK) |-> (reg_rdata == '0));
endmodule

// File: tb/gpint_unit_bench.sv
`timescale 1ns/1ps
module gpint_unit_bench;
  localparam int PINS = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PINS-1:0] pin_in = '0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [PINS-1:0] reg_wdata = '0;
  logic [PINS-1:0] reg_rdata;
  logic irq;
  int checks = 0;
  int failures = 0;

  logic [PINS-1:0] m_lvl, m_any, m_hi, m_en, m_cap, m_pin;

  always #2.5 clk = ~clk;

  gpint_unit #(.PINS(PINS)) u_gpint_unit (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [PINS-1:0] got, input logic [PINS-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [PINS-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [PINS-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [PINS-1:0] exp_raw();
    logic [PINS-1:0] r;
    for (int i = 0; i < PINS; i++)
      r[i] = m_lvl[i] ? (m_pin[i] == m_hi[i]) : m_cap[i];
    return r;
  endfunction

  task automatic step(input logic [PINS-1:0] v);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
    for (int i = 0; i < PINS; i++) begin
      logic h;
      if (m_any[i]) h = m_pin[i] ^ v[i];
      else if (m_hi[i]) h = ~m_pin[i] & v[i];
      else h = m_pin[i] & ~v[i];
      if (!m_lvl[i] && h) m_cap[i] = 1'b1;
    end
    m_pin = v;
  endtask

  task automatic chk_status(input string req);
    logic [PINS-1:0] d;
    rd(3'd4, d); chk({req, " raw"}, d, exp_raw());
    rd(3'd5, d); chk({req, " gated"}, d, exp_raw() & m_en);
    chk({req, " irq"}, {7'd0, irq}, {7'd0, |(exp_raw() & m_en)});
  endtask

  task automatic cfg(input logic [PINS-1:0] l, input logic [PINS-1:0] a,
                     input logic [PINS-1:0] h, input logic [PINS-1:0] e);
    wr(3'd0, l); wr(3'd1, a); wr(3'd2, h); wr(3'd3, e);
    m_lvl = l; m_any = a; m_hi = h; m_en = e;
  endtask

  task automatic ack(input logic [PINS-1:0] d);
    wr(3'd6, d);
    m_cap = m_cap & ~d;
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [PINS-1:0] d;
    m_lvl = '0; m_any = '0; m_hi = '0; m_en = '0; m_cap = '0; m_pin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d); chk("R1 reset read", d, '0);
    end
    chk("R1 irq", {7'd0, irq}, 8'd0);

    // R2 readback, read-only and ack index
    cfg(8'hA5, 8'h3C, 8'h96, 8'h0F);
    rd(3'd0, d); chk("R2 lvlsel", d, 8'hA5);
    rd(3'd1, d); chk("R2 anyedge", d, 8'h3C);
    rd(3'd2, d); chk("R2 acthi", d, 8'h96);
    rd(3'd3, d); chk("R2 enable", d, 8'h0F);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    chk_status("R2 ro write ignored");
    ack(8'h00);
    rd(3'd6, d); chk("R2 ack reads zero", d, '0);

    // Sweep: every pin through five modes (R3 R4 R6 R9)
    for (int m = 0; m < 5; m++) begin
      logic [PINS-1:0] l, a, h;
      for (int i = 0; i < PINS; i++) begin
        int md;
        md = (i + m) % 5;
        l[i] = (md < 2);
        h[i] = (md == 0) || (md == 2);
        a[i] = (md == 4);
      end
      cfg(l, a, h, 8'hFF >> m);
      ack(8'hFF);
      chk_status("R6 sweep start");
      for (int s = 0; s < 24; s++) begin
        logic [PINS-1:0] v;
        v = (s[0] ? 8'hFF : 8'h00) ^ 8'((s * 29 + m * 7) & 8'hFF);
        step(v);
        chk_status("R3 R4 R6 R9 sweep");
        if (s == 12) begin
          ack(8'h55);
          chk_status("R5 partial ack");
        end
      end
    end

    // R9 enable zero silences
    cfg(8'h00, 8'hFF, 8'h00, 8'h00);
    step(~m_pin);
    chk_status("R9 enable zero");
    wr(3'd3, 8'hFF); m_en = 8'hFF;
    chk_status("R9 enable all");

    // R5 sticky after pin returns, R6 ack no effect on level
    cfg(8'h00, 8'h00, 8'hFF, 8'hFF);
    step(8'h00); ack(8'hFF);
    step(8'h01); step(8'h00);
    chk_status("R5 sticky");
    cfg(8'hF0, 8'h00, 8'hFF, 8'hFF);
    step(8'hF0);
    ack(8'hF0);
    chk_status("R6 level ignores ack");
    step(8'h00);
    chk_status("R6 level drops");

    // R8 config change keeps captured bit
    cfg(8'h00, 8'h00, 8'hFF, 8'hFF);
    ack(8'hFF);
    step(8'h01);
    cfg(8'h01, 8'h00, 8'h00, 8'hFF);
    cfg(8'h00, 8'h01, 8'h00, 8'hFF);
    chk_status("R8 kept after reconfig");

    // R7 ack and edge in same cycle
    cfg(8'h00, 8'h00, 8'h02, 8'hFF);
    step(8'h00); ack(8'hFF);
    @(negedge clk);
    pin_in = 8'h02; reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h02;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(3'd4, d); chk("R7 edge beats ack", d & 8'h02, 8'h02);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule